// File: doc/BRIEF.md
# Passive Serial Configuration Host

This controller sits on the host side of a passive serial configuration link and loads a bitstream into a target device. A one-cycle `start` pulse opens a configuration attempt. The block drives the active-low request line low for a programmed number of cycles and then releases it. It then waits for the target's open-drain status line to come back high. It does not look at that line until a minimum settling time has passed. After a further programmed gap it begins clocking data. Bytes arrive from upstream on a valid/ready interface. Each byte is sent least-significant bit first, one bit per serial clock period. The low and high halves of the clock are timed separately, and these give the data setup and hold margins.

A done indication from the target during shifting ends the bitstream phase. The block then issues a set number of extra clock pulses with data low, raises `cfg_ok`, and parks the link. If status falls during shifting, the block records an abort and repeats the whole sequence from the request pulse, up to a retry limit. Upstream sees the request go low again and replays the stream from its first byte. If status stays low too long, the block flags a timeout. If the last byte goes out without done rising, it raises an incomplete-stream flag. All intervals are cycle counts of the system clock, set by parameters.

Top module: `ps_cfg_host`

## Requirements
- R1: While reset is asserted and after it, until a start: `cfg_req_n` is 1, `ser_clk` and `ser_data` are 0, `in_ready` is 0, and `cfg_ok`, `err_timeout`, `err_abort` and `err_incomplete` are all 0.
- R2: A start drives `cfg_req_n` low for exactly `T_CFG` clock cycles. The same start clears all four result flags.
- R3: `tgt_status` is not acted on until `T_SAMPLE` cycles after `cfg_req_n` falls. The first rising edge of `ser_clk` comes at least `T_ST2CK + T_CL` cycles after status is seen high, and at least `T_SAMPLE + T_ST2CK + T_CL` cycles after the request falls.
- R4: If status is still low `T_TO` cycles after the request falls, `err_timeout` is set. No serial clock is issued, and `cfg_req_n` stays high.
- R5: Each byte taken on a cycle with `in_valid` and `in_ready` both high is sent on `ser_data` with bit 0 first, one bit per `ser_clk` rising edge. Bytes follow one another until the byte marked `in_last`.
- R6: `ser_data` is stable for at least `T_CL` cycles before each `ser_clk` rising edge and for the whole `T_CH`-cycle high phase.
- R7: When `tgt_done` is high at a bit boundary (clock low), no further data bits are sent. Exactly `N_INIT` further clock pulses follow with `ser_data` low, and then `cfg_ok` is set.
- R8: Status going low during shifting sets `err_abort` and restarts from a new request pulse. The block makes at most `N_RETRY` restarts and then stops idle with `err_abort` set and `cfg_ok` clear.
- R9: If the byte marked `in_last` has been sent and `tgt_done` is low, `err_incomplete` is set and `cfg_ok` stays clear.
- R10: After success or any terminal error, `ser_clk` and `ser_data` are held at 0 and `cfg_req_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration attempt (honoured when idle or finished) |
| in_data | input | 8 | Bitstream byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | Current byte is the final one |
| in_ready | output | 1 | Block takes a byte this cycle if valid |
| cfg_req_n | output | 1 | Active-low configuration request to target |
| tgt_status | input | 1 | Target status line, low while busy or in error |
| tgt_done | input | 1 | Target done line, high when configured |
| ser_clk | output | 1 | Serial configuration clock |
| ser_data | output | 1 | Serial configuration data |
| cfg_ok | output | 1 | Configuration completed |
| err_timeout | output | 1 | Status did not release in time |
| err_abort | output | 1 | Status dropped during shifting at least once |
| err_incomplete | output | 1 | Stream ended without done |

## Verification
The bench pairs a behavioural target with a replaying byte source and runs each scenario to its end. One scenario releases status at once; a controller that ignored the sampling delay would then clock too early. Done is made to rise in the middle of a byte, which catches a controller that keeps shifting past done or sends the wrong number of trailing pulses. Status is pulled low once and then twice, so an off-by-one retry limit shows up as an extra attempt or a missing one. An overlong stream with no done must end as incomplete and not hang, and a stuck status must end as a timeout with no clock edges at all.

// File: rtl/ps_cfg_host.sv
module ps_cfg_host #(
  parameter int T_CFG    = 63,
  parameter int T_SAMPLE = 63,
  parameter int T_TO     = 28750,
  parameter int T_ST2CK  = 8,
  parameter int T_CH     = 2,
  parameter int T_CL     = 2,
  parameter int N_INIT   = 8,
  parameter int N_RETRY  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic       cfg_req_n,
  input  logic       tgt_status,
  input  logic       tgt_done,
  output logic       ser_clk,
  output logic       ser_data,
  output logic       cfg_ok,
  output logic       err_timeout,
  output logic       err_abort,
  output logic       err_incomplete
);
  localparam int CW = $clog2(T_TO + T_CFG + T_SAMPLE + T_ST2CK + T_CH + T_CL + 2);
  localparam int RW = $clog2(N_RETRY + 2);
  localparam int IW = $clog2(N_INIT + 2);

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_WAIT, S_GAP, S_LOAD, S_LO, S_HI, S_END, S_ILO, S_IHI, S_FIN
  } state_t;

  state_t         st;
  logic [CW-1:0]  cnt;
  logic [2:0]     bitn;
  logic [6:0]     shreg;
  logic           last_q;
  logic [RW-1:0]  tries;
  logic [IW-1:0]  icnt;

  wire shifting  = (st == S_LOAD) || (st == S_LO) || (st == S_HI);
  wire drop      = shifting && !tgt_status;
  wire can_start = start && ((st == S_IDLE) || (st == S_FIN));
  wire cl_end    = cnt == CW'(T_CL - 1);
  wire ch_end    = cnt == CW'(T_CH - 1);

  assign in_ready = (st == S_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= S_IDLE;
      cnt            <= '0;
      bitn           <= '0;
      shreg          <= '0;
      last_q         <= 1'b0;
      tries          <= '0;
      icnt           <= '0;
      cfg_req_n      <= 1'b1;
      ser_clk        <= 1'b0;
      ser_data       <= 1'b0;
      cfg_ok         <= 1'b0;
      err_timeout    <= 1'b0;
      err_abort      <= 1'b0;
      err_incomplete <= 1'b0;
    end else if (can_start) begin
      st             <= S_REQ;
      cnt            <= '0;
      tries          <= '0;
      cfg_req_n      <= 1'b0;
      ser_clk        <= 1'b0;
      ser_data       <= 1'b0;
      cfg_ok         <= 1'b0;
      err_timeout    <= 1'b0;
      err_abort      <= 1'b0;
      err_incomplete <= 1'b0;
    end else if (drop) begin
      err_abort <= 1'b1;
      ser_clk   <= 1'b0;
      ser_data  <= 1'b0;
      cnt       <= '0;
      if (tries < RW'(N_RETRY)) begin
        tries     <= tries + RW'(1);
        cfg_req_n <= 1'b0;
        st        <= S_REQ;
      end else begin
        st <= S_IDLE;
      end
    end else if (tgt_done && ((st == S_LOAD) || (st == S_LO) || (st == S_END))) begin
      ser_data <= 1'b0;
      ser_clk  <= 1'b0;
      cnt      <= '0;
      icnt     <= '0;
      st       <= (N_INIT == 0) ? S_FIN : S_ILO;
      cfg_ok   <= (N_INIT == 0);
    end else begin
      case (st)
        S_REQ: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(T_CFG - 1)) begin
            cfg_req_n <= 1'b1;
            st        <= S_WAIT;
          end
        end
        S_WAIT: begin
          cnt <= cnt + CW'(1);
          if (cnt >= CW'(T_SAMPLE) && tgt_status) begin
            cnt <= '0;
            st  <= S_GAP;
          end else if (cnt >= CW'(T_TO - 1)) begin
            err_timeout <= 1'b1;
            st          <= S_IDLE;
          end
        end
        S_GAP: begin
          cnt <= cnt + CW'(1);
          if (cnt >= CW'(T_ST2CK - 1)) st <= S_LOAD;
        end
        S_LOAD: begin
          if (in_valid) begin
            ser_data <= in_data[0];
            shreg    <= in_data[7:1];
            last_q   <= in_last;
            bitn     <= '0;
            cnt      <= '0;
            st       <= S_LO;
          end
        end
        S_LO: begin
          cnt <= cnt + CW'(1);
          if (cl_end) begin
            cnt     <= '0;
            ser_clk <= 1'b1;
            st      <= S_HI;
          end
        end
        S_HI: begin
          cnt <= cnt + CW'(1);
          if (ch_end) begin
            cnt     <= '0;
            ser_clk <= 1'b0;
            if (bitn == 3'd7) begin
              st <= last_q ? S_END : S_LOAD;
            end else begin
              bitn     <= bitn + 3'd1;
              ser_data <= shreg[0];
              shreg    <= shreg >> 1;
              st       <= S_LO;
            end
          end
        end
        S_END: begin
          ser_data       <= 1'b0;
          err_incomplete <= 1'b1;
          st             <= S_IDLE;
        end
        S_ILO: begin
          cnt <= cnt + CW'(1);
          if (cl_end) begin
            cnt     <= '0;
            ser_clk <= 1'b1;
            st      <= S_IHI;
          end
        end
        S_IHI: begin
          cnt <= cnt + CW'(1);
          if (ch_end) begin
            cnt     <= '0;
            ser_clk <= 1'b0;
            if (icnt == IW'(N_INIT - 1)) begin
              cfg_ok <= 1'b1;
              st     <= S_FIN;
            end else begin
              icnt <= icnt + IW'(1);
              st   <= S_ILO;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ps_cfg_host_chk.sv
module ps_cfg_host_chk #(
  parameter int T_CFG = 63
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_req_n,
  input logic ser_clk,
  input logic ser_data,
  input logic in_ready,
  input logic cfg_ok,
  input logic err_timeout,
  input logic err_incomplete
);
  int lowc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowc <= 0;
    else        lowc <= cfg_req_n ? 0 : lowc + 1;
  end

  p_req_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req_n) |-> lowc == T_CFG);

  p_no_clk_in_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req_n |-> !ser_clk);

  p_timeout_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> cfg_req_n && !ser_clk);

  p_take_clk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !ser_clk && cfg_req_n);

  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data));

  p_single_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_ok, err_timeout, err_incomplete}));

  p_parked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |-> !ser_clk && !ser_data && cfg_req_n);
endmodule

bind ps_cfg_host ps_cfg_host_chk #(.T_CFG(T_CFG)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_req_n(cfg_req_n), .ser_clk(ser_clk),
  .ser_data(ser_data), .in_ready(in_ready), .cfg_ok(cfg_ok),
  .err_timeout(err_timeout), .err_incomplete(err_incomplete)
);

// File: tb/ps_cfg_host_test.sv
module ps_cfg_host_test;
  localparam int T_CFG = 5, T_SAMPLE = 8, T_TO = 60, T_ST2CK = 3;
  localparam int T_CH = 2, T_CL = 3, N_INIT = 4, N_RETRY = 1;
  localparam int NV = 8;
  // nbytes, status-low cycles after release, done after bits, aborts, abort bit, outcome
  // outcome: 0 success, 1 timeout, 2 abort limit reached, 3 incomplete
  localparam int VEC [NV][6] = '{
    '{4, 10, 32, 0, 0, 0},
    '{1,  0,  8, 0, 0, 0},
    '{2, 200, 16, 0, 0, 1},
    '{6, 20, 40, 0, 0, 0},
    '{3, 10, 24, 1, 5, 0},
    '{3, 10, 24, 2, 9, 2},
    '{2,  6, 100, 0, 0, 3},
    '{5, 15, 37, 0, 0, 0}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] in_data = 0;
  logic in_valid = 0, in_last = 0, tgt_status = 1, tgt_done = 1;
  logic in_ready, cfg_req_n, ser_clk, ser_data, cfg_ok, err_timeout, err_abort, err_incomplete;

  ps_cfg_host #(.T_CFG(T_CFG), .T_SAMPLE(T_SAMPLE), .T_TO(T_TO), .T_ST2CK(T_ST2CK),
    .T_CH(T_CH), .T_CL(T_CL), .N_INIT(N_INIT), .N_RETRY(N_RETRY)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .cfg_req_n(cfg_req_n), .tgt_status(tgt_status),
    .tgt_done(tgt_done), .ser_clk(ser_clk), .ser_data(ser_data), .cfg_ok(cfg_ok),
    .err_timeout(err_timeout), .err_abort(err_abort), .err_incomplete(err_incomplete));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int sc = 0, nbytes = 0, stlow = 0, doneat = 1000, aborts = 0, abit = 0;
  int cyc = 0, st_cnt = 1000000, bits_rx = 0, idx = 0, attempts = 0, mism = 0;
  int setup_v = 0, hold_v = 0, stab = 0, reqlow = 0, req_w = 0, rises = 0;
  int fall_cyc = 0, sthi_cyc = 0, rise_cyc = -1, post_rises = 0, post_high = 0;
  bit force_low = 0, take = 0, prev_clk = 0, prev_req = 1, prev_data = 0, prev_st = 1;

  function automatic logic [7:0] pat(int s, int i);
    return 8'((i * 53 + s * 29 + 7) ^ (i << 3));
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s scen=%0d actual=%0d expected=%0d", req, sc, act, exp);
    end
  endtask

  task automatic chk_ge(string req, int act, int lim);
    total++;
    if (act < lim) begin
      bad++;
      $display("FAIL %s scen=%0d actual=%0d expected>=%0d", req, sc, act, lim);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!cfg_req_n) begin
      if (prev_req) begin
        attempts++; reqlow = 0; fall_cyc = cyc; rise_cyc = -1;
      end
      reqlow++;
      tgt_status = 0; tgt_done = 0; bits_rx = 0; st_cnt = 0; idx = 0; take = 0;
      force_low = 0; post_rises = 0; post_high = 0;
    end else begin
      if (!prev_req) req_w = reqlow;
      if (force_low) tgt_status = 0;
      else if (st_cnt < stlow) begin st_cnt++; tgt_status = 0; end
      else tgt_status = 1;
    end
    if (tgt_status && !prev_st) sthi_cyc = cyc;
    if (ser_data == prev_data) stab++; else stab = 0;
    if (ser_clk && prev_clk && ser_data != prev_data) hold_v++;
    if (ser_clk && !prev_clk) begin
      rises++;
      if (rise_cyc < 0) rise_cyc = cyc;
      if (stab < T_CL) setup_v++;
      if (!tgt_done) begin
        if (ser_data != pat(sc, bits_rx / 8)[bits_rx % 8]) mism++;
        bits_rx++;
        if (bits_rx == doneat) tgt_done = 1;
        if (attempts <= aborts && bits_rx == abit) force_low = 1;
      end else begin
        post_rises++;
        if (ser_data) post_high++;
      end
    end
    if (take) idx++;
    in_valid = cfg_req_n && idx < nbytes;
    in_data  = pat(sc, idx);
    in_last  = (idx == nbytes - 1);
    take     = in_ready && in_valid;
    prev_clk = ser_clk; prev_req = cfg_req_n; prev_data = ser_data; prev_st = tgt_status;
  end

  task automatic chk_idle(string req);
    chk({req, " req_n"}, cfg_req_n, 1);
    chk({req, " clk"}, ser_clk, 0);
    chk({req, " data"}, ser_data, 0);
  endtask

  initial begin
    int timer = 0;
    while (timer < 150000) begin @(posedge clk); timer++; end
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk_idle("R1 in reset");
    chk("R1 ready", in_ready, 0);
    chk("R1 flags", {cfg_ok, err_timeout, err_abort, err_incomplete}, 0);
    @(posedge clk); #1 rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("R1 after reset");

    for (int v = 0; v < NV; v++) begin
      int code, exp_att;
      @(posedge clk); #1;
      sc = v; nbytes = VEC[v][0]; stlow = VEC[v][1]; doneat = VEC[v][2];
      aborts = VEC[v][3]; abit = VEC[v][4]; code = VEC[v][5];
      attempts = 0; mism = 0; setup_v = 0; hold_v = 0; rises = 0; req_w = 0;
      start = 1;
      @(posedge clk); #1 start = 0;
      repeat (1500) @(posedge clk);
      @(negedge clk);
      exp_att = (code == 1) ? 1 : ((aborts < N_RETRY) ? aborts : N_RETRY) + 1;
      chk("R2 request width", req_w, T_CFG);
      chk("R8 attempts", attempts, exp_att);
      chk("R7 cfg_ok", cfg_ok, code == 0);
      chk("R4 timeout flag", err_timeout, code == 1);
      chk("R8 abort flag", err_abort, aborts > 0);
      chk("R9 incomplete flag", err_incomplete, code == 3);
      chk("R6 setup", setup_v, 0);
      chk("R6 hold", hold_v, 0);
      chk_idle("R10 parked");
      if (code == 1) chk("R4 no clock", rises, 0);
      if (code == 0 || code == 3) begin
        chk("R5 bit errors", mism, 0);
        chk("R5 bit count", bits_rx, code == 0 ? doneat : nbytes * 8);
        chk_ge("R3 gap from status", rise_cyc - sthi_cyc, T_ST2CK + T_CL);
        chk_ge("R3 gap from request", rise_cyc - fall_cyc, T_SAMPLE + T_ST2CK + T_CL);
      end
      if (code == 0) begin
        chk("R7 extra clocks", post_rises, N_INIT);
        chk("R7 extra data low", post_high, 0);
      end
    end

    // R1: reset in the middle of shifting returns the link to rest
    @(posedge clk); #1;
    sc = 0; nbytes = 4; stlow = 3; doneat = 32; aborts = 0; abit = 0;
    start = 1;
    @(posedge clk); #1 start = 0;
    repeat (60) @(posedge clk);
    #1 rst_n = 0;
    @(negedge clk);
    chk_idle("R1 mid-run reset");
    chk("R1 mid-run flags", {cfg_ok, err_timeout, err_abort, err_incomplete}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule